// File: doc/BRIEF.md
# UART Receive Idle Time-out Timer

This block watches the receive side of a serial port for silence. It lets software find where a frame of unknown length ends. A down-counter is loaded with a programmed number of bit periods. It counts one step on each bit-period strobe from the baud generator and is reloaded whenever the receiver reports a new character. When the count runs out, a sticky time-out flag is set, and an interrupt request follows if it is enabled.

Software arms the timer with one of two command strobes:
- **Wait-then-count.** The counter is held frozen until the first character arrives. An idle line before a frame never produces a time-out.
- **Count-now.** The counter starts at once. Issuing this command again after each expiry gives a periodic tick while the line stays silent, for example to detect keypad inactivity.

A programmed value of zero turns detection off completely.

Top module: `rx_idle_timer`

## Requirements
- R1: After synchronous reset, `timeout_flag` and `irq` are 0 and the timer is unarmed: bit strobes and received characters cause no time-out until a command arrives.
- R2: A `cmd_count_now` pulse loads `timeout_val`, and the flag reads 1 after exactly `timeout_val` bit strobes (not after one fewer). Repeating the command re-runs the same interval.
- R3: After a `cmd_wait_char` pulse, bit strobes do not advance the counter until a character is received. The flag then reads 1 after `timeout_val` further strobes.
- R4: A `char_rcvd` pulse while counting reloads `timeout_val`, so the interval restarts from that character. A character in the same cycle as a strobe reloads and does not count that strobe.
- R5: While `timeout_val` is 0, the flag never becomes 1 in either arming mode.
- R6: After expiry the counter stops at zero. Further strobes or characters raise no new time-out until a command re-arms it. A character does not clear the flag.
- R7: The flag is cleared by `clr_flag`, by `cmd_wait_char` and by `cmd_count_now`, and by nothing else.
- R8: When a command and `char_rcvd` arrive in the same cycle, the command wins. With `cmd_wait_char`, the timer stays frozen and that character does not start the count. If both commands arrive together, `cmd_count_now` takes priority.
- R9: `irq` equals `timeout_flag` AND `irq_en` in the same cycle.
- R10: If `clr_flag` and an expiry happen in the same cycle, the flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_val | input | 16 | Programmed time-out in bit periods; 0 disables |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| char_rcvd | input | 1 | One-cycle pulse per received character |
| cmd_wait_char | input | 1 | Arm: hold until first character, then count |
| cmd_count_now | input | 1 | Arm: load and count at once |
| clr_flag | input | 1 | Clear the time-out flag |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky time-out status |
| irq | output | 1 | Interrupt request |

## Verification
A received character can land in the same cycle as an arming command, and an expiry can coincide with a flag clear. The bench provokes the first case by pulsing `char_rcvd` together with `cmd_wait_char` mid-count. It then judges that the timer stayed frozen by applying more strobes than the interval without seeing the flag, followed by a real character and an exact-count expiry. The second case drives the final strobe together with `clr_flag` and expects the flag set afterwards.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   typedef enum logic [1:0] {
      ARM_OFF  = 2'd0,
      ARM_WAIT = 2'd1,
      ARM_RUN  = 2'd2,
      ARM_DONE = 2'd3
   } arm_state_t;

   typedef struct packed {
      logic load;
      logic dec;
      logic expire;
   } cnt_ctl_t;
endpackage

// File: rtl/rxto_counter.sv
module rxto_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             dec,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             cnt_last
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (dec && count != '0)
         count <= count - ONE;
   end

   assign cnt_last = (count <= ONE);

   // R2
   dec_step_chk: assert property (@(posedge clk) disable iff (rst)
      (dec && !load && count > ONE) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/rxto_arm.sv
module rxto_arm (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cmd_wait,
   input  logic                   cmd_now,
   input  logic                   char_in,
   input  logic                   tick,
   input  logic                   val_zero,
   input  logic                   cnt_last,
   output rxto_pkg::cnt_ctl_t     ctl,
   output rxto_pkg::arm_state_t   state
);
   import rxto_pkg::*;

   arm_state_t nxt;

   always_comb begin
      nxt = state;
      ctl = '0;
      if (cmd_now) begin
         ctl.load = 1'b1;
         nxt      = ARM_RUN;
      end else if (cmd_wait) begin
         ctl.load = 1'b1;
         nxt      = ARM_WAIT;
      end else begin
         unique case (state)
            ARM_WAIT: if (char_in) begin
               ctl.load = 1'b1;
               nxt      = ARM_RUN;
            end
            ARM_RUN: begin
               if (char_in)
                  ctl.load = 1'b1;
               else if (tick && !val_zero) begin
                  ctl.dec = 1'b1;
                  if (cnt_last) begin
                     ctl.expire = 1'b1;
                     nxt        = ARM_DONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ARM_OFF;
      else     state <= nxt;
   end

   // R8
   cmd_wait_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_wait && !cmd_now) |=> (state == ARM_WAIT));
   // R6
   done_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ARM_DONE && !cmd_wait && !cmd_now) |=> (state == ARM_DONE));
   // R1
   off_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ARM_OFF && !cmd_wait && !cmd_now) |=> (state == ARM_OFF));
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (rst)      flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= flag & irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = flag & irq_en;
      end
   endgenerate
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] timeout_val,
   input  logic             bit_tick,
   input  logic             char_rcvd,
   input  logic             cmd_wait_char,
   input  logic             cmd_count_now,
   input  logic             clr_flag,
   input  logic             irq_en,
   output logic             timeout_flag,
   output logic             irq
);
   import rxto_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("rx_idle_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   cnt_ctl_t         ctl;
   arm_state_t       state;
   logic [CNT_W-1:0] count;
   logic             cnt_last;
   logic             val_zero;
   logic             any_cmd;

   assign val_zero = (timeout_val == '0);
   assign any_cmd  = cmd_wait_char | cmd_count_now;

   rxto_arm u_arm (
      .clk(clk), .rst(rst),
      .cmd_wait(cmd_wait_char), .cmd_now(cmd_count_now),
      .char_in(char_rcvd), .tick(bit_tick),
      .val_zero(val_zero), .cnt_last(cnt_last),
      .ctl(ctl), .state(state)
   );

   rxto_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(ctl.load), .dec(ctl.dec), .load_val(timeout_val),
      .count(count), .cnt_last(cnt_last)
   );

   rxto_flag #(.IRQ_REG(IRQ_REG)) u_flag (
      .clk(clk), .rst(rst),
      .set(ctl.expire), .clr(clr_flag | any_cmd),
      .irq_en(irq_en), .flag(timeout_flag), .irq(irq)
   );

   // R3
   wait_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ARM_WAIT && !any_cmd && !char_rcvd) |=> $stable(count));
   // R5
   zero_disables_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(timeout_flag) |-> ($past(timeout_val) != '0));
   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (timeout_flag && !clr_flag && !any_cmd) |=> timeout_flag);
   // R10
   set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.expire && clr_flag) |=> timeout_flag);
   // R4
   char_reload_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ARM_RUN && char_rcvd && !any_cmd) |=> (count == $past(timeout_val)));
endmodule

// File: tb/sim_rx_idle_timer.sv
module sim_rx_idle_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] timeout_val = '0;
   logic        bit_tick = 0, char_rcvd = 0, cmd_wait_char = 0, cmd_count_now = 0;
   logic        clr_flag = 0, irq_en = 0;
   logic        timeout_flag, irq;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_idle_timer u0 (
      .clk(clk), .rst(rst), .timeout_val(timeout_val), .bit_tick(bit_tick),
      .char_rcvd(char_rcvd), .cmd_wait_char(cmd_wait_char),
      .cmd_count_now(cmd_count_now), .clr_flag(clr_flag), .irq_en(irq_en),
      .timeout_flag(timeout_flag), .irq(irq)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", what, act, exp);
      end
   endtask

   // inputs change on negedge; one pulse lasts exactly one posedge
   task automatic step();
      @(negedge clk);
      bit_tick = 0; char_rcvd = 0; cmd_wait_char = 0; cmd_count_now = 0; clr_flag = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1; step();
         step();
      end
   endtask

   task automatic count_now();  cmd_count_now = 1; step(); endtask
   task automatic wait_char();  cmd_wait_char = 1; step(); endtask
   task automatic char_in();    char_rcvd = 1;     step(); endtask
   task automatic clear();      clr_flag = 1;      step(); endtask

   task automatic t_reset();
      chk(timeout_flag, 0, "R1 flag after reset");
      chk(irq, 0, "R1 irq after reset");
      irq_en = 1; timeout_val = 2;
      ticks(4); char_in(); ticks(4);
      chk(timeout_flag, 0, "R1 unarmed timer stays quiet");
   endtask

   task automatic t_count_now();
      timeout_val = 5; count_now();
      ticks(4);
      chk(timeout_flag, 0, "R2 one strobe short");
      ticks(1);
      chk(timeout_flag, 1, "R2 expiry at exact count");
      count_now();
      chk(timeout_flag, 0, "R7 count-now clears flag");
      ticks(4);
      chk(timeout_flag, 0, "R2 periodic one short");
      ticks(1);
      chk(timeout_flag, 1, "R2 periodic second expiry");
   endtask

   task automatic t_wait_char();
      timeout_val = 4; wait_char();
      chk(timeout_flag, 0, "R7 wait-char clears flag");
      ticks(10);
      chk(timeout_flag, 0, "R3 frozen before first character");
      char_in(); ticks(3);
      chk(timeout_flag, 0, "R3 one strobe short after char");
      ticks(1);
      chk(timeout_flag, 1, "R3 expiry after char");
   endtask

   task automatic t_char_reload();
      timeout_val = 4; count_now();
      ticks(3); char_in(); ticks(3);
      chk(timeout_flag, 0, "R4 char restarted interval");
      bit_tick = 1; char_rcvd = 1; step(); step();
      ticks(3);
      chk(timeout_flag, 0, "R4 char beats strobe in same cycle");
      ticks(1);
      chk(timeout_flag, 1, "R4 expiry after reload");
   endtask

   task automatic t_after_expiry();
      char_in();
      chk(timeout_flag, 1, "R6 char does not clear flag");
      clear();
      chk(timeout_flag, 0, "R7 clear strobe clears flag");
      ticks(8); char_in(); ticks(8);
      chk(timeout_flag, 0, "R6 stopped counter raises nothing");
   endtask

   task automatic t_irq();
      timeout_val = 1; count_now(); ticks(1);
      irq_en = 0; #1;
      chk(irq, 0, "R9 irq masked");
      irq_en = 1; #1;
      chk(irq, 1, "R9 irq enabled");
      clear();
      chk(irq, 0, "R9 irq follows clear");
   endtask

   task automatic t_zero();
      timeout_val = 0; count_now(); ticks(20);
      chk(timeout_flag, 0, "R5 zero value count-now");
      wait_char(); char_in(); ticks(20);
      chk(timeout_flag, 0, "R5 zero value wait-char");
   endtask

   task automatic t_collide();
      timeout_val = 3; count_now(); ticks(1);
      cmd_wait_char = 1; char_rcvd = 1; step();
      ticks(6);
      chk(timeout_flag, 0, "R8 command beat same-cycle char");
      char_in(); ticks(2);
      chk(timeout_flag, 0, "R8 counting started by later char");
      ticks(1);
      chk(timeout_flag, 1, "R8 expiry from later char");
      cmd_wait_char = 1; cmd_count_now = 1; step();
      ticks(2);
      chk(timeout_flag, 0, "R8 both commands one short");
      ticks(1);
      chk(timeout_flag, 1, "R8 count-now has priority");
   endtask

   task automatic t_set_vs_clear();
      timeout_val = 2; count_now(); ticks(1);
      bit_tick = 1; clr_flag = 1; step();
      chk(timeout_flag, 1, "R10 expiry beats clear");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      step();
      t_reset();
      t_count_now();
      t_wait_char();
      t_char_reload();
      t_after_expiry();
      t_irq();
      t_zero();
      t_collide();
      t_set_vs_clear();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule